// File: doc/BRIEF.md
# Two-Wire Gamma Setting Register Slave

This block is a write-only slave on a two-wire serial bus that holds the level settings for a display gamma reference generator. It owns eleven 10-bit setting registers: ten gamma channels and one common-voltage channel. Their values are presented in parallel to the converter that follows. A bus master loads a register with a fixed four-byte write: the device address, a register selector, then two data bytes. Each data byte carries its own even-parity bit.

SCL and SDA are oversampled by the system clock through two-flop synchronisers. The block only ever pulls SDA low, and it does so only in the acknowledge slot. Two strap inputs give four address choices, so four of these devices can share one bus. One selector value writes a single setting into every channel at once. A register changes only after the last data byte arrives with both parity checks good. A START or STOP at any point puts the byte engine back at the beginning of a frame.

Top module: `gamma_i2c_regs`

## Requirements
- R1: While reset is asserted, every channel reads 0 and SDA is not driven.
- R2: The first byte after START is acknowledged only when its upper seven bits equal 1,1,1,0,1,strap_a2,strap_a1 (MSB first) and its LSB (the direction bit) is 0. Any other first byte gets no acknowledge, and the frame writes nothing.
- R3: In a matched frame, the block acknowledges the address byte and each of the three bytes that follow by holding SDA low through the ninth SCL high phase.
- R4: Bits 3..0 of the second byte select the target: 0x0 to 0x9 select gamma channels 0 to 9, and 0xA selects the common channel (channel 10). Bits 7..4 of that byte are ignored.
- R5: The written value takes bits 9..3 from bits 7..1 of the third byte and bits 2..0 from bits 7..5 of the fourth byte. Bits 4..1 of the fourth byte are ignored.
- R6: In the third and fourth bytes, bit 0 makes that byte's count of ones even. If either byte fails this check, the write is discarded and no channel changes.
- R7: Selector 0xF writes the same value into all eleven channels.
- R8: Selectors 0xB to 0xE are acknowledged on every byte but change no channel.
- R9: A frame cut short by STOP or by a repeated START before the fourth byte completes writes nothing. A repeated START begins a new frame at the address byte.
- R10: Channel k appears on ch_value[10k+9:10k], and SDA is sampled on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a1 | input | 1 | Address strap, lowest address bit |
| strap_a2 | input | 1 | Address strap, next address bit |
| ch_value | output | 110 | Eleven 10-bit settings, channel 0 in the low bits |

## Verification
Two things start from the same SCL edge: the register update and the start of the acknowledge. The eighth rising edge of the fourth byte both fires the write and moves the engine toward driving SDA low. The bench therefore checks two things for the same frame. It samples the acknowledge in the ninth clock's high phase, and once STOP has passed it compares the full output against a model. Bad-parity, truncated and repeated-START frames are run through that same edge to confirm that the acknowledge is still given while the write is held back.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic [1:0] {
    LS_IDLE,
    LS_BITS,
    LS_ACK_SETUP,
    LS_ACK_HOLD
  } link_state_t;

  function automatic logic even_ok(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/gi_sync_edge.sv
module gi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/gi_link.sv
module gi_link
  import gamma_pkg::*;
#(
  parameter logic [4:0] DEV_HI = 5'b11101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       strap_a1,
  input  logic       strap_a2,
  output logic       byte_stb,
  output logic [1:0] byte_idx,
  output logic [7:0] byte_data,
  output logic       ack_drv
);
  link_state_t st_q, st_n;
  logic [2:0]  cnt_q, cnt_n;
  logic [1:0]  idx_q, idx_n;
  logic [7:0]  sh_q, sh_n;
  logic        ack_q, ack_n;
  logic        stb_q, stb_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    sh_n  = sh_q;
    ack_n = ack_q;
    stb_n = 1'b0;
    if (start_det) begin
      st_n  = LS_BITS;
      cnt_n = '0;
      idx_n = '0;
      ack_n = 1'b0;
    end else if (stop_det) begin
      st_n  = LS_IDLE;
      ack_n = 1'b0;
    end else begin
      case (st_q)
        LS_BITS: if (scl_rise) begin
          sh_n  = {sh_q[6:0], sda_s};
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (idx_q == 2'd0) begin
              if (sh_n[7:1] == {DEV_HI, strap_a2, strap_a1} && !sh_n[0])
                st_n = LS_ACK_SETUP;
              else
                st_n = LS_IDLE;
            end else begin
              stb_n = 1'b1;
              st_n  = LS_ACK_SETUP;
            end
          end
        end
        LS_ACK_SETUP: if (scl_fall) begin
          ack_n = 1'b1;
          st_n  = LS_ACK_HOLD;
        end
        LS_ACK_HOLD: if (scl_fall) begin
          ack_n = 1'b0;
          idx_n = idx_q + 2'd1;
          cnt_n = '0;
          st_n  = (idx_q == 2'd3) ? LS_IDLE : LS_BITS;
        end
        default: st_n = LS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LS_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      sh_q  <= sh_n;
      ack_q <= ack_n;
      stb_q <= stb_n;
    end
  end

  assign byte_stb  = stb_q;
  assign byte_idx  = idx_q;
  assign byte_data = sh_q;
  assign ack_drv   = ack_q;
endmodule

// File: rtl/gi_regbank.sv
module gi_regbank
  import gamma_pkg::*;
#(
  parameter int         DATA_W = 10,
  parameter int         N_CH   = 11,
  parameter logic [3:0] BCAST  = 4'hF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_det,
  input  logic                   byte_stb,
  input  logic [1:0]             byte_idx,
  input  logic [7:0]             byte_data,
  output logic [N_CH*DATA_W-1:0] ch_value
);
  localparam int HI_W = DATA_W - 3;

  logic [3:0]      sel_q, sel_n;
  logic [HI_W-1:0] hi_q, hi_n;
  logic            hi_ok_q, hi_ok_n;
  logic            wr;
  logic [DATA_W-1:0] wval;

  always_comb begin
    sel_n   = sel_q;
    hi_n    = hi_q;
    hi_ok_n = hi_ok_q;
    if (start_det) begin
      hi_ok_n = 1'b0;
    end else if (byte_stb) begin
      if (byte_idx == 2'd1) sel_n = byte_data[3:0];
      if (byte_idx == 2'd2) begin
        hi_n    = byte_data[7:8-HI_W];
        hi_ok_n = even_ok(byte_data);
      end
      if (byte_idx == 2'd3) hi_ok_n = 1'b0;
    end
  end

  assign wr   = byte_stb && (byte_idx == 2'd3) && hi_ok_q && even_ok(byte_data);
  assign wval = {hi_q, byte_data[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      hi_q    <= '0;
      hi_ok_q <= 1'b0;
    end else begin
      sel_q   <= sel_n;
      hi_q    <= hi_n;
      hi_ok_q <= hi_ok_n;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [DATA_W-1:0] val_q;
    logic              hit;
    assign hit = wr && ((sel_q == 4'(k)) || (sel_q == BCAST));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wval;
    end
    assign ch_value[k*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/gamma_i2c_regs.sv
module gamma_i2c_regs #(
  parameter int         DATA_W  = 10,
  parameter int         N_CH    = 11,
  parameter int         SYNC_ST = 2,
  parameter logic [4:0] DEV_HI  = 5'b11101,
  parameter logic [3:0] BCAST   = 4'hF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_oe,
  input  logic                   strap_a1,
  input  logic                   strap_a2,
  output logic [N_CH*DATA_W-1:0] ch_value
);
  logic [1:0] rst_q;
  logic       rst_int_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_stb;
  logic [1:0] byte_idx;
  logic [7:0] byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  gi_sync_edge #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  gi_link #(.DEV_HI(DEV_HI)) u_link (
    .clk(clk), .rst_n(rst_int_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_a1(strap_a1), .strap_a2(strap_a2), .byte_stb(byte_stb),
    .byte_idx(byte_idx), .byte_data(byte_data), .ack_drv(sda_oe)
  );

  gi_regbank #(.DATA_W(DATA_W), .N_CH(N_CH), .BCAST(BCAST)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .start_det(start_det), .byte_stb(byte_stb),
    .byte_idx(byte_idx), .byte_data(byte_data), .ch_value(ch_value)
  );
endmodule

// File: rtl/gamma_i2c_chk.sv
module gamma_i2c_chk #(
  parameter int VW = 110
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic [VW-1:0] ch_value,
  input logic          byte_stb,
  input logic [1:0]    byte_idx,
  input logic [7:0]    byte_data,
  input logic          scl_s,
  input logic          start_det
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (ch_value == '0 && !sda_oe));

  // R6
  bad_parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_idx == 2'd3 && (^byte_data)) |=> $stable(ch_value));

  // R9
  write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_value) |-> $past(byte_stb && byte_idx == 2'd3));

  // R3
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

bind gamma_i2c_regs gamma_i2c_chk #(.VW(N_CH*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ch_value(ch_value),
  .byte_stb(byte_stb), .byte_idx(byte_idx), .byte_data(byte_data),
  .scl_s(scl_s), .start_det(start_det)
);

// File: tb/sim_gamma_i2c_regs.sv
`timescale 1ns/1ps
module sim_gamma_i2c_regs;
  localparam int DW = 10;
  localparam int NC = 11;
  localparam int VW = DW*NC;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, strap_a1, strap_a2;
  logic sda_oe;
  logic [VW-1:0] ch_value;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [NC];
  logic [VW-1:0] exp_q [$];
  string         tag_q [$];
  event          mon_ev;

  always #2 clk = ~clk;

  gamma_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .strap_a1(strap_a1), .strap_a2(strap_a2),
    .ch_value(ch_value)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [VW-1:0] pack_model();
    logic [VW-1:0] v;
    for (int k = 0; k < NC; k++) v[k*DW +: DW] = model[k];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(8);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(8);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(8);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(8);
    scl_m = 1'b1; tick(5);
    got = !sda_bus;
    check(got == exp_ack, req, "acknowledge", VW'(got), VW'(exp_ack));
    tick(5);
    scl_m = 1'b0; tick(2);
  endtask

  // Driver: runs one frame and queues the expected register image.
  task automatic txn(input logic [6:0] dev, input bit rw, input logic [7:0] b1,
                     input logic [9:0] d, input bit flip_hi, input bit flip_lo,
                     input logic [3:0] dc, input int nbytes, input bit end_stop,
                     input string req);
    logic [7:0] b2, b3;
    bit match;
    b2 = {d[9:3], (^d[9:3]) ^ flip_hi};
    b3 = {d[2:0], dc, (^{d[2:0], dc}) ^ flip_lo};
    match = (dev == {5'b11101, strap_a2, strap_a1}) && !rw;
    do_start();
    send_byte({dev, rw}, match, req);
    if (match) begin
      if (nbytes > 1) send_byte(b1, 1'b1, req);
      if (nbytes > 2) send_byte(b2, 1'b1, req);
      if (nbytes > 3) send_byte(b3, 1'b1, req);
    end
    if (end_stop) do_stop();
    if (match && nbytes == 4 && !flip_hi && !flip_lo) begin
      if (b1[3:0] == 4'hF) begin
        for (int k = 0; k < NC; k++) model[k] = d;
      end else if (b1[3:0] <= 4'hA) begin
        model[b1[3:0]] = d;
      end
    end
    exp_q.push_back(pack_model());
    tag_q.push_back(req);
    -> mon_ev;
    tick(4);
  endtask

  // Monitor: pops the expected image and compares it with the outputs.
  initial begin
    forever begin
      @(mon_ev);
      tick(2);
      while (exp_q.size() > 0) begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ch_value === e, t, "register image", ch_value, e);
      end
    end
  end

  initial begin
    #(150000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap_a1 = 1'b0; strap_a2 = 1'b0;
    for (int k = 0; k < NC; k++) model[k] = '0;
    tick(5);
    // R1: reset state
    check(ch_value == '0, "R1", "reset value", ch_value, '0);
    check(sda_oe == 1'b0, "R1", "sda released in reset", VW'(sda_oe), '0);
    rst_n = 1'b1; tick(10);

    // R2 R3 R4 R5 R10: plain write to channel 0
    txn(7'b1110100, 0, 8'h00, 10'h3A5, 0, 0, 4'h0, 4, 1, "R5");
    // R4: common channel, upper nibble of selector ignored
    txn(7'b1110100, 0, 8'h7A, 10'h155, 0, 0, 4'h6, 4, 1, "R4");
    // R2: wrong device address and read direction
    txn(7'b1110110, 0, 8'h01, 10'h111, 0, 0, 4'h0, 4, 1, "R2");
    txn(7'b1110100, 1, 8'h01, 10'h111, 0, 0, 4'h0, 4, 1, "R2");
    // R6: parity failure on either data byte
    txn(7'b1110100, 0, 8'h02, 10'h2AA, 1, 0, 4'h0, 4, 1, "R6");
    txn(7'b1110100, 0, 8'h02, 10'h2AA, 0, 1, 4'h0, 4, 1, "R6");
    // R7: broadcast, then a single channel over it
    txn(7'b1110100, 0, 8'h0F, 10'h2C3, 0, 0, 4'h0, 4, 1, "R7");
    txn(7'b1110100, 0, 8'h05, 10'h001, 0, 0, 4'h0, 4, 1, "R7");
    // R8: unused selectors
    txn(7'b1110100, 0, 8'h0C, 10'h3FF, 0, 0, 4'h0, 4, 1, "R8");
    txn(7'b1110100, 0, 8'h0B, 10'h3FF, 0, 0, 4'h0, 4, 1, "R8");
    // R9: stop after three bytes, then repeated start after three bytes
    txn(7'b1110100, 0, 8'h03, 10'h0F0, 0, 0, 4'h0, 3, 1, "R9");
    txn(7'b1110100, 0, 8'h03, 10'h0F0, 0, 0, 4'h0, 3, 0, "R9");
    txn(7'b1110100, 0, 8'h09, 10'h3FF, 0, 0, 4'h0, 4, 1, "R9");
    // R5: ignored bits of fourth byte, zero value
    txn(7'b1110100, 0, 8'h00, 10'h000, 0, 0, 4'hB, 4, 1, "R5");
    txn(7'b1110100, 0, 8'h08, 10'h24D, 0, 0, 4'h5, 4, 1, "R5");
    // R2: straps moved to a2=1, a1=0
    strap_a2 = 1'b1; tick(4);
    txn(7'b1110100, 0, 8'h01, 10'h123, 0, 0, 4'h0, 4, 1, "R2");
    txn(7'b1110110, 0, 8'h01, 10'h123, 0, 0, 4'h0, 4, 1, "R2");
    strap_a1 = 1'b1; strap_a2 = 1'b0; tick(4);
    txn(7'b1110101, 0, 8'h06, 10'h0AB, 0, 0, 4'h0, 4, 1, "R2");

    tick(20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule